// File: doc/BRIEF.md
# Two-Channel Ordered Break Trigger

This block turns the match strobes of two bus-cycle comparator channels, called A and B, into one break request for the debug logic. Each channel has a sticky match flag. Hardware sets the flag and software clears it. A channel match counts only when the bus tag of the current cycle equals the bus that channel is set to watch.

In normal mode the two channels act independently, and either one can request a break. In sequential mode the channels form a two-step trigger. A match on channel A arms the trigger, and a later match on channel B requests the break. An optional down-counter on the channel B side can require several B matches before the break is requested.

The address and data comparators are outside the block and appear only as strobes. The break request is registered: it is high for the one cycle that follows the clock edge at which the deciding match was sampled.

Top module: `seq_break_unit`

## Requirements
- R1: With `seq_en`=1, `brk_req` pulses only when a qualified channel B match arrives while the trigger is already armed by an earlier channel A match. The pulse appears one cycle after the B strobe is sampled.
- R2: With `seq_en`=1, a qualified channel B match that arrives while the trigger is not armed produces no break.
- R3: With `seq_en`=1, if the trigger is not armed and A and B match in the same cycle, no break is requested. That A match still arms the trigger, so a later B match breaks.
- R4: An armed trigger is cancelled only when `seq_en`=0 and `a_clr`=1 hold in the same cycle. Dropping `seq_en` alone leaves it armed. Pulsing `a_clr` alone with `seq_en`=1 also leaves it armed.
- R5: A strobe on a channel qualifies only when its cycle tag equals that channel's bus select (0 = CPU instruction/data bus, 1 = internal peripheral bus). A strobe that does not qualify sets no flag and requests no break.
- R6: When `cnt_en`=1, each qualified B match that is eligible decrements the counter, but only while the counter is above 1. A B match requests a break only when the counter is 1 or less. `cnt_load` loads `cnt_value` into the counter. In sequential mode, B matches are eligible only while the trigger is armed.
- R7: After a sequential break the trigger returns to unarmed. A further B match needs a new A match before it can break.
- R8: With `seq_en`=0, a qualified A match always requests a break. A qualified B match requests a break subject to the counter condition of R6.
- R9: Each flag is set by a qualified match of its channel and stays set until that channel's clear strobe is given. A set in the same cycle as a clear wins.
- R10: After reset both flags are 0, `brk_req` is 0, the trigger is unarmed and the counter holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_hit | input | 1 | Channel A comparator match strobe |
| a_hit_bus | input | 1 | Bus tag of the channel A strobe's cycle |
| a_sel_bus | input | 1 | Bus that channel A watches |
| b_hit | input | 1 | Channel B comparator match strobe |
| b_hit_bus | input | 1 | Bus tag of the channel B strobe's cycle |
| b_sel_bus | input | 1 | Bus that channel B watches |
| seq_en | input | 1 | Sequential mode enable |
| cnt_en | input | 1 | Execution-count condition enable |
| cnt_load | input | 1 | Load strobe for the counter |
| cnt_value | input | CNT_W | Counter load value |
| a_clr | input | 1 | Clear strobe for the channel A flag |
| b_clr | input | 1 | Clear strobe for the channel B flag |
| a_flag | output | 1 | Sticky channel A match flag |
| b_flag | output | 1 | Sticky channel B match flag |
| brk_req | output | 1 | One-cycle break request |

## Verification
The armed state has no output of its own, so it is the hardest thing to observe from the ports. This matters most when software tries to cancel it with only one of the two required actions. The stimulus first arms the trigger with an A match. It then applies one disarm action at a time, either dropping `seq_en` or pulsing `a_clr`, and after each one sends a B match. Whether a break pulse follows shows whether the trigger was still armed. The counter is probed the same way: the bench counts how many armed B matches pass before the break appears.

// File: rtl/seq_break_unit.sv
module seq_break_unit #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_hit,
  input  logic             a_hit_bus,
  input  logic             a_sel_bus,
  input  logic             b_hit,
  input  logic             b_hit_bus,
  input  logic             b_sel_bus,
  input  logic             seq_en,
  input  logic             cnt_en,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             a_clr,
  input  logic             b_clr,
  output logic             a_flag,
  output logic             b_flag,
  output logic             brk_req
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed;
  logic [CNT_W-1:0] cnt_q;

  wire qa       = a_hit && (a_hit_bus == a_sel_bus);
  wire qb       = b_hit && (b_hit_bus == b_sel_bus);
  wire cnt_done = (cnt_q <= CNT_ONE);
  wire b_elig   = seq_en ? armed : 1'b1;
  wire b_fire   = qb && b_elig && (!cnt_en || cnt_done);
  wire brk_d    = seq_en ? b_fire : (qa || b_fire);
  wire disarm   = !seq_en && a_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_flag  <= 1'b0;
      b_flag  <= 1'b0;
      brk_req <= 1'b0;
      armed   <= 1'b0;
      cnt_q   <= CNT_ONE;
    end else begin
      a_flag  <= qa ? 1'b1 : (a_clr ? 1'b0 : a_flag);
      b_flag  <= qb ? 1'b1 : (b_clr ? 1'b0 : b_flag);
      brk_req <= brk_d;

      if ((seq_en && b_fire) || disarm) armed <= 1'b0;
      else if (seq_en && qa)            armed <= 1'b1;

      if (cnt_load)
        cnt_q <= cnt_value;
      else if (cnt_en && qb && b_elig && !cnt_done)
        cnt_q <= cnt_q - CNT_ONE;
    end
  end

  AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && qb && !armed) |=> !brk_req);  // R2

  AST_NO_SIMUL_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !armed && qa && qb) |=> (!brk_req && armed));  // R3

  AST_CLR_ALONE_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && seq_en && a_clr && !qb) |=> armed);  // R4

  AST_DISARM_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && armed && brk_d) |=> (brk_req && !armed));  // R7

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !cnt_load) |=> (cnt_q != '0));  // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flag && !a_clr) |=> a_flag);  // R9

  AST_NORMAL_A_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en && qa) |=> brk_req);  // R8

endmodule

// File: tb/seq_break_unit_bench.sv
module seq_break_unit_bench;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_hit = 0, a_hit_bus = 0, a_sel_bus = 0;
  logic b_hit = 0, b_hit_bus = 0, b_sel_bus = 0;
  logic seq_en = 0, cnt_en = 0, cnt_load = 0, a_clr = 0, b_clr = 0;
  logic [CNT_W-1:0] cnt_value = '0;
  logic a_flag, b_flag, brk_req;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  seq_break_unit #(.CNT_W(CNT_W)) u_seq_break_unit (
    .clk(clk), .rst_n(rst_n),
    .a_hit(a_hit), .a_hit_bus(a_hit_bus), .a_sel_bus(a_sel_bus),
    .b_hit(b_hit), .b_hit_bus(b_hit_bus), .b_sel_bus(b_sel_bus),
    .seq_en(seq_en), .cnt_en(cnt_en), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .a_clr(a_clr), .b_clr(b_clr),
    .a_flag(a_flag), .b_flag(b_flag), .brk_req(brk_req));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes; outputs are sampled at the following negedge.
  task automatic cyc(input logic a, input logic abus, input logic b, input logic bbus);
    a_hit = a; a_hit_bus = abus; b_hit = b; b_hit_bus = bbus;
    @(negedge clk);
    a_hit = 0; b_hit = 0;
  endtask

  task automatic clr_all();
    seq_en = 0; a_clr = 1; b_clr = 1;
    @(negedge clk);
    a_clr = 0; b_clr = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 a_flag", a_flag, 1'b0);
    check("R10 b_flag", b_flag, 1'b0);
    check("R10 brk_req", brk_req, 1'b0);
  endtask

  task automatic t_normal();
    clr_all();
    cyc(1, 0, 0, 0);
    check("R8 A break", brk_req, 1'b1);
    check("R9 A flag set", a_flag, 1'b1);
    cyc(0, 0, 1, 0);
    check("R8 B break", brk_req, 1'b1);
    check("R9 B flag set", b_flag, 1'b1);
    cyc(0, 0, 0, 0);
    check("R8 idle no break", brk_req, 1'b0);
    check("R9 A flag sticky", a_flag, 1'b1);
    a_clr = 1; cyc(1, 0, 0, 0); a_clr = 0;
    check("R9 set wins over clear", a_flag, 1'b1);
    a_clr = 1; cyc(0, 0, 0, 0); a_clr = 0;
    check("R9 A flag cleared", a_flag, 1'b0);
    check("R9 B flag unaffected", b_flag, 1'b1);
  endtask

  task automatic t_seq_basic();
    clr_all(); seq_en = 1;
    cyc(1, 0, 0, 0);
    check("R1 A alone no break", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R1 B after A breaks", brk_req, 1'b1);
    cyc(0, 0, 0, 0);
    check("R1 pulse one cycle", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R7 rearm needed", brk_req, 1'b0);
  endtask

  task automatic t_b_first();
    clr_all(); seq_en = 1;
    cyc(0, 0, 1, 0);
    check("R2 B first no break", brk_req, 1'b0);
    check("R2 B flag still set", b_flag, 1'b1);
    cyc(1, 0, 0, 0);
    check("R2 A after B no break", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R2 then B breaks", brk_req, 1'b1);
  endtask

  task automatic t_simul();
    clr_all(); seq_en = 1;
    cyc(1, 0, 1, 0);
    check("R3 simultaneous no break", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R3 armed by simultaneous A", brk_req, 1'b1);
  endtask

  task automatic t_disarm();
    clr_all(); seq_en = 1;
    cyc(1, 0, 0, 0);
    seq_en = 0; cyc(0, 0, 0, 0); seq_en = 1;
    cyc(0, 0, 1, 0);
    check("R4 seq drop alone keeps arm", brk_req, 1'b1);
    cyc(1, 0, 0, 0);
    a_clr = 1; cyc(0, 0, 0, 0); a_clr = 0;
    check("R4 clear alone clears flag", a_flag, 1'b0);
    cyc(0, 0, 1, 0);
    check("R4 clear alone keeps arm", brk_req, 1'b1);
    cyc(1, 0, 0, 0);
    seq_en = 0; a_clr = 1; cyc(0, 0, 0, 0); a_clr = 0; seq_en = 1;
    cyc(0, 0, 1, 0);
    check("R4 both actions disarm", brk_req, 1'b0);
  endtask

  task automatic t_bus();
    clr_all(); seq_en = 1; a_sel_bus = 1; b_sel_bus = 0;
    cyc(1, 0, 0, 0);
    check("R5 A wrong bus no flag", a_flag, 1'b0);
    cyc(0, 0, 1, 0);
    check("R5 A wrong bus no arm", brk_req, 1'b0);
    b_clr = 1; cyc(1, 1, 0, 0); b_clr = 0;
    check("R5 A right bus flag", a_flag, 1'b1);
    cyc(0, 0, 1, 1);
    check("R5 B wrong bus no break", brk_req, 1'b0);
    check("R5 B wrong bus no flag", b_flag, 1'b0);
    cyc(0, 0, 1, 0);
    check("R5 B right bus breaks", brk_req, 1'b1);
    a_sel_bus = 0;
  endtask

  task automatic t_count();
    clr_all(); seq_en = 1; cnt_en = 1;
    cnt_value = 12'd3; cnt_load = 1; @(negedge clk); cnt_load = 0;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    check("R6 count 3 first B", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R6 count 2 second B", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R6 count 1 third B breaks", brk_req, 1'b1);
    cnt_value = 12'd2; cnt_load = 1; @(negedge clk); cnt_load = 0;
    cyc(0, 0, 1, 0);
    check("R6 unarmed B no break", brk_req, 1'b0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    check("R6 unarmed B did not count", brk_req, 1'b0);
    cyc(0, 0, 1, 0);
    check("R6 count floor break", brk_req, 1'b1);
    seq_en = 0;
    cyc(0, 0, 1, 0);
    check("R8 B at floor breaks normal", brk_req, 1'b1);
    cnt_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_normal();
    t_seq_basic();
    t_b_first();
    t_simul();
    t_disarm();
    t_bus();
    t_count();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule